// File: doc/BRIEF.md
# Hub Downstream Routing and Driver-Speed Control

This block sits in the repeater of a hub with one upstream port and four downstream ports. For every packet that arrives from the host side it decides which downstream ports are driven and whether each one uses its slow-edge driver. Ports that hold a full-speed device receive ordinary traffic at once. Ports that hold a low-speed device stay silent until a preamble packet identifier has been seen. A fixed number of full-speed bit times after that identifier, their slow drivers are switched on. All of them are released when the end of packet is detected.

When the upstream side is idle and a downstream port reports activity, the block instead turns on the upstream transmitter. That direction always uses full-speed drivers, so there is no speed select for it. A frame timer counts full-speed bit ticks and restarts whenever a start-of-frame identifier arrives.

All outputs are registered. A change on an input shows on the outputs at the clock edge that samples it.

Top module: `hub_ls_router`

## Requirements
- R1: While reset is held, and right after it is released, every transmit enable, every slow-driver select and the frame count are zero.
- R2: One cycle after an upstream packet start (`us_sop`) in idle, `ds_tx_en` equals the enabled ports that are not flagged low-speed. `ds_ls_drv` stays zero.
- R3: A port whose `port_en` bit was low in the previous cycle never has its `ds_tx_en` bit set. This holds even in the middle of a packet.
- R4: A valid PID byte 8'h3C marks a preamble. Its low nibble 4'b1100 is the type and its high nibble is the bitwise complement. If this byte arrives during a full-speed packet, then one cycle after the LS_ON_TICKS-th `bit_tick` (default 4) `ds_tx_en` equals all enabled ports and `ds_ls_drv` equals the enabled low-speed ports.
- R5: Before that last tick, low-speed ports stay off and only the full-speed set of R2 is driven.
- R6: A PID byte whose high nibble is not the complement of its low nibble is ignored for gating. For example, 8'h0C never turns on low-speed ports.
- R7: One cycle after `eop_done` during a downstream packet, every `ds_tx_en` and `ds_ls_drv` bit is zero.
- R8: `ds_ls_drv` is set only on ports flagged low-speed, and only where `ds_tx_en` is also set.
- R9: In idle with `ds_rx_act` high, `up_tx_en` rises on the next cycle and stays high until the cycle after `ds_rx_act` falls. While `up_tx_en` is high, no downstream enable is set.
- R10: `frame_cnt` becomes 0 one cycle after a valid PID byte 8'hA5 (start of frame). Otherwise it rises by one per `bit_tick` and saturates at its maximum value.
- R11: In idle, `us_sop` takes priority over `ds_rx_act`. While upstream forwarding is active, `us_sop` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 4 | Per-port enabled flag |
| port_ls | input | 4 | Per-port low-speed device flag |
| us_sop | input | 1 | Start of a packet from upstream |
| pid_vld | input | 1 | Strobe: `pid` holds a decoded PID byte |
| pid | input | 8 | PID byte: type in bits 3:0, complement in bits 7:4 |
| bit_tick | input | 1 | One pulse per full-speed bit time |
| eop_done | input | 1 | End of packet detected |
| ds_rx_act | input | 1 | A downstream port is receiving a packet |
| ds_tx_en | output | 4 | Per-port downstream transmit enable |
| ds_ls_drv | output | 4 | Per-port low-speed driver select |
| up_tx_en | output | 1 | Upstream transmit enable |
| frame_cnt | output | 14 | Bit ticks since the last start of frame |

## Verification
The checks assume the following about the inputs:
- `eop_done` never coincides with a new `us_sop`.
- `ds_rx_act` is raised only between packets.
- PID strobes come only inside packets opened by `us_sop`.

The stimulus follows these rules. It sends each packet as start, PID, ticks and end on separate cycles. It raises downstream activity only after the previous packet has closed. Bit ticks are spaced by idle cycles, so the bench counts ticks rather than clock cycles.

// File: rtl/hub_rpt_pkg.sv
package hub_rpt_pkg;
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_FS,
        RS_PRE,
        RS_LS,
        RS_UP
    } rpt_state_e;

    localparam logic [3:0] PID_TYPE_PRE = 4'b1100;
    localparam logic [3:0] PID_TYPE_SOF = 4'b0101;
endpackage

// File: rtl/hub_pid_check.sv
module hub_pid_check
    import hub_rpt_pkg::*;
(
    input  logic       pid_vld,
    input  logic [7:0] pid,
    output logic       pre_hit,
    output logic       sof_hit
);
    logic chk_ok;

    always_comb begin
        chk_ok  = (pid[7:4] == ~pid[3:0]);
        pre_hit = pid_vld && chk_ok && (pid[3:0] == PID_TYPE_PRE);
        sof_hit = pid_vld && chk_ok && (pid[3:0] == PID_TYPE_SOF);
    end
endmodule

// File: rtl/hub_frame_timer.sv
module hub_frame_timer #(
    parameter int FRAME_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_hit,
    input  logic               bit_tick,
    output logic [FRAME_W-1:0] frame_cnt
);
    localparam logic [FRAME_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [FRAME_W-1:0] cnt;
    } ft_t;

    ft_t ft_d, ft_q;

    always_comb begin
        ft_d = ft_q;
        if (sof_hit) begin
            ft_d.cnt = '0;
        end else if (bit_tick && (ft_q.cnt != CNT_MAX)) begin
            ft_d.cnt = ft_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ft_q <= '0;
        else        ft_q <= ft_d;
    end

    assign frame_cnt = ft_q.cnt;
endmodule

// File: rtl/hub_route_fsm.sv
module hub_route_fsm
    import hub_rpt_pkg::*;
#(
    parameter int NPORT       = 4,
    parameter int LS_ON_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] port_en,
    input  logic [NPORT-1:0] port_ls,
    input  logic             us_sop,
    input  logic             pre_hit,
    input  logic             bit_tick,
    input  logic             eop_done,
    input  logic             ds_rx_act,
    output logic [NPORT-1:0] ds_tx_en,
    output logic [NPORT-1:0] ds_ls_drv,
    output logic             up_tx_en
);
    localparam int CNT_W = (LS_ON_TICKS > 1) ? $clog2(LS_ON_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(LS_ON_TICKS - 1);

    typedef struct packed {
        rpt_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [NPORT-1:0] tx;
        logic [NPORT-1:0] ls;
        logic             up;
    } rf_t;

    rf_t rf_d, rf_q;

    logic [NPORT-1:0] fs_mask;
    logic [NPORT-1:0] all_mask;
    logic [NPORT-1:0] slow_mask;

    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        assign fs_mask[p]   = port_en[p] & ~port_ls[p];
        assign all_mask[p]  = port_en[p];
        assign slow_mask[p] = port_en[p] &  port_ls[p];
    end

    always_comb begin
        rf_d = rf_q;
        unique case (rf_q.st)
            RS_IDLE: begin
                if (us_sop)         rf_d.st = RS_FS;
                else if (ds_rx_act) rf_d.st = RS_UP;
            end
            RS_FS: begin
                if (eop_done) begin
                    rf_d.st = RS_IDLE;
                end else if (pre_hit) begin
                    rf_d.st  = RS_PRE;
                    rf_d.cnt = '0;
                end
            end
            RS_PRE: begin
                if (eop_done) begin
                    rf_d.st = RS_IDLE;
                end else if (bit_tick) begin
                    if (rf_q.cnt == LAST_TICK) rf_d.st = RS_LS;
                    else                       rf_d.cnt = rf_q.cnt + 1'b1;
                end
            end
            RS_LS: begin
                if (eop_done) rf_d.st = RS_IDLE;
            end
            RS_UP: begin
                if (!ds_rx_act) rf_d.st = RS_IDLE;
            end
            default: rf_d.st = RS_IDLE;
        endcase

        rf_d.tx = '0;
        rf_d.ls = '0;
        rf_d.up = 1'b0;
        unique case (rf_d.st)
            RS_FS, RS_PRE: rf_d.tx = fs_mask;
            RS_LS: begin
                rf_d.tx = all_mask;
                rf_d.ls = slow_mask;
            end
            RS_UP:   rf_d.up = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q    <= '0;
            rf_q.st <= RS_IDLE;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign ds_tx_en  = rf_q.tx;
    assign ds_ls_drv = rf_q.ls;
    assign up_tx_en  = rf_q.up;
endmodule

// File: rtl/hub_ls_router.sv
module hub_ls_router #(
    parameter int NPORT       = 4,
    parameter int FRAME_W     = 14,
    parameter int LS_ON_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPORT-1:0]   port_en,
    input  logic [NPORT-1:0]   port_ls,
    input  logic               us_sop,
    input  logic               pid_vld,
    input  logic [7:0]         pid,
    input  logic               bit_tick,
    input  logic               eop_done,
    input  logic               ds_rx_act,
    output logic [NPORT-1:0]   ds_tx_en,
    output logic [NPORT-1:0]   ds_ls_drv,
    output logic               up_tx_en,
    output logic [FRAME_W-1:0] frame_cnt
);
    logic pre_hit;
    logic sof_hit;

    hub_pid_check i_pid (
        .pid_vld (pid_vld),
        .pid     (pid),
        .pre_hit (pre_hit),
        .sof_hit (sof_hit)
    );

    hub_frame_timer #(.FRAME_W(FRAME_W)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_hit   (sof_hit),
        .bit_tick  (bit_tick),
        .frame_cnt (frame_cnt)
    );

    hub_route_fsm #(.NPORT(NPORT), .LS_ON_TICKS(LS_ON_TICKS)) i_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .port_ls   (port_ls),
        .us_sop    (us_sop),
        .pre_hit   (pre_hit),
        .bit_tick  (bit_tick),
        .eop_done  (eop_done),
        .ds_rx_act (ds_rx_act),
        .ds_tx_en  (ds_tx_en),
        .ds_ls_drv (ds_ls_drv),
        .up_tx_en  (up_tx_en)
    );
endmodule

// File: rtl/hub_ls_router_chk.sv
module hub_ls_router_chk #(
    parameter int NPORT   = 4,
    parameter int FRAME_W = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NPORT-1:0]   port_en,
    input logic [NPORT-1:0]   port_ls,
    input logic               pid_vld,
    input logic [7:0]         pid,
    input logic               eop_done,
    input logic [NPORT-1:0]   ds_tx_en,
    input logic [NPORT-1:0]   ds_ls_drv,
    input logic               up_tx_en,
    input logic [FRAME_W-1:0] frame_cnt
);
    logic sof_in;
    assign sof_in = pid_vld && (pid == 8'hA5);

    // R3
    a_r3_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((ds_tx_en & ~$past(port_en)) == '0));

    // R8
    a_r8_ls_within_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_ls_drv & ~ds_tx_en) == '0);

    // R8
    a_r8_ls_only_slow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((ds_ls_drv & ~$past(port_ls)) == '0));

    // R7
    a_r7_eop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        eop_done |=> (ds_tx_en == '0 && ds_ls_drv == '0));

    // R9
    a_r9_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_tx_en && (ds_tx_en != '0)));

    // R10
    a_r10_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sof_in |=> (frame_cnt == '0));

    // R10
    a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !sof_in) |=>
            (frame_cnt == $past(frame_cnt) || frame_cnt == $past(frame_cnt) + 1'b1));
endmodule

bind hub_ls_router hub_ls_router_chk #(.NPORT(NPORT), .FRAME_W(FRAME_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .port_ls   (port_ls),
    .pid_vld   (pid_vld),
    .pid       (pid),
    .eop_done  (eop_done),
    .ds_tx_en  (ds_tx_en),
    .ds_ls_drv (ds_ls_drv),
    .up_tx_en  (up_tx_en),
    .frame_cnt (frame_cnt)
);

// File: tb/test_hub_ls_router.sv
module test_hub_ls_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  port_en = '0;
    logic [3:0]  port_ls = '0;
    logic        us_sop = 1'b0;
    logic        pid_vld = 1'b0;
    logic [7:0]  pid = '0;
    logic        bit_tick = 1'b0;
    logic        eop_done = 1'b0;
    logic        ds_rx_act = 1'b0;
    logic [3:0]  ds_tx_en;
    logic [3:0]  ds_ls_drv;
    logic        up_tx_en;
    logic [13:0] frame_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    hub_ls_router i_hub_ls_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .port_ls   (port_ls),
        .us_sop    (us_sop),
        .pid_vld   (pid_vld),
        .pid       (pid),
        .bit_tick  (bit_tick),
        .eop_done  (eop_done),
        .ds_rx_act (ds_rx_act),
        .ds_tx_en  (ds_tx_en),
        .ds_ls_drv (ds_ls_drv),
        .up_tx_en  (up_tx_en),
        .frame_cnt (frame_cnt)
    );

    // Vector fields: {port_en, port_ls, full-speed set, set after preamble, slow-driver set}
    localparam int NVEC = 6;
    localparam logic [19:0] VEC [NVEC] = '{
        {4'hF, 4'h0, 4'hF, 4'hF, 4'h0},
        {4'hF, 4'hF, 4'h0, 4'hF, 4'hF},
        {4'hF, 4'h5, 4'hA, 4'hF, 4'h5},
        {4'h6, 4'h3, 4'h4, 4'h6, 4'h2},
        {4'h0, 4'hA, 4'h0, 4'h0, 4'h0},
        {4'h9, 4'h8, 4'h1, 4'h9, 4'h8}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_pid(input logic [7:0] b);
        pid = b; pid_vld = 1'b1;
        step();
        pid_vld = 1'b0;
    endtask

    task automatic tick_gap();
        bit_tick = 1'b1;
        step();
        bit_tick = 1'b0;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        chk("R1 tx", {28'd0, ds_tx_en}, 0);
        chk("R1 ls", {28'd0, ds_ls_drv}, 0);
        rst_n = 1'b1;
        step();
        chk("R1 up", {31'd0, up_tx_en}, 0);
        chk("R1 frame", {18'd0, frame_cnt}, 0);

        // Table walk: R2, R4, R5, R7, R8
        for (int v = 0; v < NVEC; v++) begin
            port_en = VEC[v][19:16];
            port_ls = VEC[v][15:12];
            us_sop  = 1'b1;
            step();
            us_sop  = 1'b0;
            chk("R2 fs set", {28'd0, ds_tx_en}, {28'd0, VEC[v][11:8]});
            chk("R2 no slow", {28'd0, ds_ls_drv}, 0);
            send_pid(8'h3C);
            for (int t = 0; t < 3; t++) tick_gap();
            chk("R5 before last tick", {28'd0, ds_tx_en}, {28'd0, VEC[v][11:8]});
            chk("R5 slow off", {28'd0, ds_ls_drv}, 0);
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            chk("R4 all enabled", {28'd0, ds_tx_en}, {28'd0, VEC[v][7:4]});
            chk("R8 slow drivers", {28'd0, ds_ls_drv}, {28'd0, VEC[v][3:0]});
            eop_done = 1'b1;
            step();
            eop_done = 1'b0;
            chk("R7 tx cleared", {28'd0, ds_tx_en}, 0);
            chk("R7 ls cleared", {28'd0, ds_ls_drv}, 0);
        end

        // R6: bad check nibble ignored
        port_en = 4'hF; port_ls = 4'h5;
        us_sop = 1'b1; step(); us_sop = 1'b0;
        send_pid(8'h0C);
        for (int t = 0; t < 5; t++) tick_gap();
        chk("R6 slow ports stay off", {28'd0, ds_tx_en}, 32'hA);
        chk("R6 no slow drivers", {28'd0, ds_ls_drv}, 0);
        eop_done = 1'b1; step(); eop_done = 1'b0;

        // R3: disable a port during a low-speed packet
        us_sop = 1'b1; step(); us_sop = 1'b0;
        send_pid(8'h3C);
        for (int t = 0; t < 4; t++) tick_gap();
        chk("R3 pre-check", {28'd0, ds_tx_en}, 32'hF);
        port_en = 4'hE;
        step();
        chk("R3 disabled port off", {28'd0, ds_tx_en}, 32'hE);
        chk("R3 slow driver follows", {28'd0, ds_ls_drv}, 32'h4);
        eop_done = 1'b1; step(); eop_done = 1'b0;
        port_en = 4'hF;

        // R9 and R11: upstream forwarding
        ds_rx_act = 1'b1;
        step();
        chk("R9 up on", {31'd0, up_tx_en}, 1);
        chk("R9 ds quiet", {28'd0, ds_tx_en}, 0);
        us_sop = 1'b1; step(); us_sop = 1'b0;
        chk("R11 sop ignored while up", {28'd0, ds_tx_en}, 0);
        chk("R9 up held", {31'd0, up_tx_en}, 1);
        ds_rx_act = 1'b0;
        step();
        chk("R9 up off", {31'd0, up_tx_en}, 0);
        us_sop = 1'b1; ds_rx_act = 1'b1;
        step();
        us_sop = 1'b0; ds_rx_act = 1'b0;
        chk("R11 sop priority tx", {28'd0, ds_tx_en}, 32'hA);
        chk("R11 sop priority up", {31'd0, up_tx_en}, 0);
        eop_done = 1'b1; step(); eop_done = 1'b0;

        // R10: frame timer
        send_pid(8'hA5);
        chk("R10 sof zero", {18'd0, frame_cnt}, 0);
        for (int t = 0; t < 10; t++) tick_gap();
        chk("R10 count ticks", {18'd0, frame_cnt}, 10);
        send_pid(8'hA4);
        chk("R10 bad sof ignored", {18'd0, frame_cnt}, 10);
        send_pid(8'hA5);
        chk("R10 restart", {18'd0, frame_cnt}, 0);
        bit_tick = 1'b1;
        repeat (16400) step();
        bit_tick = 1'b0;
        chk("R10 saturate", {18'd0, frame_cnt}, 32'h3FFF);

        finish_run();
    end
endmodule